// File: doc/BRIEF.md
# Thread-Block Dispatcher with Load-Balancing Steal

This block hands 16-bit thread-block IDs to a fixed set of compute cores. Each core owns a preloaded queue that holds an ordered group of block IDs, kept as a circular buffer with a head pointer, a tail pointer and an occupancy count. The load port appends one ID per cycle to the tail of a chosen core's queue. A core asks for work by pulsing its request bit. The dispatcher then grants that core the oldest ID in its own queue, and it can serve every core in the same cycle.

A core may ask for work while its own queue is empty. In that case the dispatcher takes a batch of IDs from the core with the largest backlog. The batch size is that peak backlog minus the mean backlog. The mean is the sum of all counts divided by the number of cores, rounded down. The batch comes from the back of the donor's queue, so the donor keeps working through its front entries in their original order. A steal copies one entry per cycle, and only one steal runs at a time. While a steal is in progress, grants and loads are held off. The done flag reports that no queued or unacknowledged work remains.

Top module: `block_dispatch`

## Requirements
- R1: After reset, `gnt_valid` is all zero and `done` is 1.
- R2: A load (`load_valid` high, `load_sm` = core index, `load_id`) appends the ID to that core's queue, and each core's grants come out in the order its IDs were queued. No grant appears on a core that has no pending request.
- R3: A request pulse on `sm_req[i]` to a non-empty queue, with no steal active, produces a one-cycle `gnt_valid[i]` exactly two clock edges later. The ID appears on `gnt_id[16*i +: 16]`.
- R4: Requests from several cores with non-empty queues are granted on the same clock edge.
- R5: A pending request to an empty queue starts a steal. The donor is the core with the largest count; on a tie, the lowest index wins. The batch is peak minus floor(sum of counts / number of cores).
- R6: The batch is the donor's last entries. The thief receives them in their original order, and the donor keeps issuing its head entries in order.
- R7: If the batch size is zero, nothing moves and no grant is given. The request stays pending and is served once an ID reaches that core's queue.
- R8: Only one steal runs at a time, and the lowest-index starving core goes first. Each steal of k IDs stalls all grants for k+1 cycles. A load presented during those cycles is ignored.
- R9: `done` is 1 exactly when every queue is empty, every granted ID has been acknowledged on `sm_ack`, and no steal is in progress.
- R10: Every loaded ID that is accepted is granted exactly once across all cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Append `load_id` to queue `load_sm` |
| load_sm | input | SW | Target core of a load |
| load_id | input | 16 | Block ID to queue |
| sm_req | input | N_SM | Per-core one-cycle request for a block |
| sm_ack | input | N_SM | Per-core pulse: a granted block has finished |
| gnt_valid | output | N_SM | Per-core one-cycle grant strobe |
| gnt_id | output | 16*N_SM | Granted IDs, core i in bits 16*i +: 16 |
| done | output | 1 | No queued, stolen or unacknowledged work |

## Verification
The bench sets up a tie between the two largest backlogs while a third core is starving. A design that chose the higher-index donor, or that took the batch from the head of the queue, would hand out IDs out of the order the scoreboard expects. Grant latency is measured across a steal, which catches a design that lets other cores' grants slip through while the donor's pointers are moving. A load is injected in the middle of a steal, and a design that accepted it would later issue an ID that was never expected. Finally, a core requests with every queue empty and then receives a late load. A design that dropped the pending request, or that produced a phantom grant, would be caught.

// File: rtl/bd_pkg.sv
package bd_pkg;

  localparam int ID_W   = 16;
  localparam int STAT_W = 16;

  typedef enum logic [0:0] {ST_IDLE, ST_MOVE} steal_state_e;

  // floor of the mean backlog across all cores
  function automatic logic [STAT_W-1:0] mean_backlog(
    input logic [STAT_W-1:0] total,
    input int unsigned       n_sm
  );
    return total / STAT_W'(n_sm);
  endfunction

  // number of IDs moved by one steal
  function automatic logic [STAT_W-1:0] batch_size(
    input logic [STAT_W-1:0] peak,
    input logic [STAT_W-1:0] mean
  );
    return (peak > mean) ? (peak - mean) : '0;
  endfunction

endpackage

// File: rtl/bd_queue.sv
module bd_queue
  import bd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  logic            pop,
  input  logic            drop_tail,
  input  logic            fill_we,
  input  logic [PW-1:0]   fill_idx,
  input  logic [ID_W-1:0] fill_id,
  input  logic            fill_done,
  input  logic [CW-1:0]   fill_len,
  output logic [ID_W-1:0] head_id,
  output logic [ID_W-1:0] tail_id,
  output logic [CW-1:0]   count
);

  logic [ID_W-1:0] slots [DEPTH];
  logic [PW-1:0]   hd_q;
  logic [PW-1:0]   tl_q;

  // pointers: a finished refill rebases the queue at slot 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= '0;
      tl_q  <= '0;
      count <= '0;
    end else if (fill_done) begin
      hd_q  <= '0;
      tl_q  <= PW'(fill_len);
      count <= fill_len;
    end else begin
      if (pop)            hd_q <= hd_q + 1'b1;
      if (push)           tl_q <= tl_q + 1'b1;
      else if (drop_tail) tl_q <= tl_q - 1'b1;
      count <= count + CW'(push) - CW'(pop) - CW'(drop_tail);
    end
  end

  always_ff @(posedge clk) begin
    if (push)    slots[tl_q]     <= push_id;
    if (fill_we) slots[fill_idx] <= fill_id;
  end

  assign head_id = slots[hd_q];
  assign tail_id = slots[tl_q - 1'b1];

endmodule

// File: rtl/bd_steal.sv
module bd_steal
  import bd_pkg::*;
#(
  parameter int N_SM  = 4,
  parameter int DEPTH = 16,
  localparam int SW = (N_SM > 1) ? $clog2(N_SM) : 1,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SM-1:0]   starving,
  input  logic [N_SM*CW-1:0] cnt_flat,
  output logic              start,
  output logic              busy,
  output logic              move,
  output logic              finish,
  output logic [SW-1:0]     thief,
  output logic [SW-1:0]     donor,
  output logic [PW-1:0]     move_idx,
  output logic [CW-1:0]     batch_len,
  output logic [STAT_W-1:0] peak_q,
  output logic [STAT_W-1:0] mean_q,
  output logic [STAT_W-1:0] batch_q
);

  steal_state_e      state_q;
  logic [STAT_W-1:0] remain_q;
  logic [SW-1:0]     thief_q, donor_q;

  logic [STAT_W-1:0] peak_c, total_c, mean_c, batch_c;
  logic [SW-1:0]     donor_c, thief_c;
  logic              have_thief;

  // largest backlog (first one wins a tie), total backlog, lowest starving core
  always_comb begin
    peak_c     = '0;
    total_c    = '0;
    donor_c    = '0;
    thief_c    = '0;
    have_thief = 1'b0;
    for (int i = 0; i < N_SM; i++) begin
      total_c = total_c + STAT_W'(cnt_flat[i*CW +: CW]);
      if (STAT_W'(cnt_flat[i*CW +: CW]) > peak_c) begin
        peak_c  = STAT_W'(cnt_flat[i*CW +: CW]);
        donor_c = SW'(i);
      end
    end
    for (int i = N_SM - 1; i >= 0; i--) begin
      if (starving[i]) begin
        thief_c    = SW'(i);
        have_thief = 1'b1;
      end
    end
  end

  assign mean_c  = mean_backlog(total_c, N_SM);
  assign batch_c = batch_size(peak_c, mean_c);

  assign start     = (state_q == ST_IDLE) && have_thief && (batch_c != '0);
  assign busy      = (state_q == ST_MOVE);
  assign move      = busy;
  assign finish    = busy && (remain_q == STAT_W'(1));
  assign move_idx  = PW'(remain_q - STAT_W'(1));
  assign batch_len = CW'(batch_q);
  assign thief     = thief_q;
  assign donor     = donor_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      thief_q  <= '0;
      donor_q  <= '0;
      peak_q   <= '0;
      mean_q   <= '0;
      batch_q  <= '0;
    end else if (start) begin
      state_q  <= ST_MOVE;
      remain_q <= batch_c;
      thief_q  <= thief_c;
      donor_q  <= donor_c;
      peak_q   <= peak_c;
      mean_q   <= mean_c;
      batch_q  <= batch_c;
    end else if (move) begin
      remain_q <= remain_q - STAT_W'(1);
      if (finish) state_q <= ST_IDLE;
    end
  end

endmodule

// File: rtl/block_dispatch.sv
module block_dispatch
  import bd_pkg::*;
#(
  parameter int N_SM   = 4,
  parameter int QDEPTH = 16,
  localparam int SW = (N_SM > 1) ? $clog2(N_SM) : 1,
  localparam int PW = $clog2(QDEPTH),
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_valid,
  input  logic [SW-1:0]        load_sm,
  input  logic [ID_W-1:0]      load_id,
  input  logic [N_SM-1:0]      sm_req,
  input  logic [N_SM-1:0]      sm_ack,
  output logic [N_SM-1:0]      gnt_valid,
  output logic [N_SM*ID_W-1:0] gnt_id,
  output logic                 done
);

  logic [N_SM-1:0]    pending_q;
  logic [N_SM-1:0]    serve, starving;
  logic [N_SM*CW-1:0] cnt_flat;
  logic [ID_W-1:0]    head_arr [N_SM];
  logic [ID_W-1:0]    tail_arr [N_SM];
  logic [ID_W-1:0]    gid_q    [N_SM];
  logic [ID_W-1:0]    donor_tail;
  logic [15:0]        out_q, n_srv, n_ack;
  logic               all_empty;

  // named steal events for the checker
  logic               steal_start, steal_busy, steal_move, steal_finish;
  logic               stall;
  logic [SW-1:0]      thief_q, donor_q;
  logic [PW-1:0]      move_idx;
  logic [CW-1:0]      batch_len;
  logic [STAT_W-1:0]  peak_q, mean_q, batch_q;

  assign stall      = steal_start || steal_busy;
  assign donor_tail = tail_arr[donor_q];

  bd_steal #(.N_SM(N_SM), .DEPTH(QDEPTH)) u_steal (
    .clk       (clk),
    .rst_n     (rst_n),
    .starving  (starving),
    .cnt_flat  (cnt_flat),
    .start     (steal_start),
    .busy      (steal_busy),
    .move      (steal_move),
    .finish    (steal_finish),
    .thief     (thief_q),
    .donor     (donor_q),
    .move_idx  (move_idx),
    .batch_len (batch_len),
    .peak_q    (peak_q),
    .mean_q    (mean_q),
    .batch_q   (batch_q)
  );

  for (genvar g = 0; g < N_SM; g++) begin : g_sm
    logic [CW-1:0] occ;
    logic          is_thief, is_donor, do_push;

    assign occ      = cnt_flat[g*CW +: CW];
    assign is_thief = (thief_q == SW'(g));
    assign is_donor = (donor_q == SW'(g));
    assign do_push  = load_valid && !stall && (load_sm == SW'(g)) && (occ != CW'(QDEPTH));
    assign serve[g]    = pending_q[g] && (occ != '0) && !stall;
    assign starving[g] = pending_q[g] && (occ == '0);

    bd_queue #(.DEPTH(QDEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (do_push),
      .push_id   (load_id),
      .pop       (serve[g]),
      .drop_tail (steal_move && is_donor),
      .fill_we   (steal_move && is_thief),
      .fill_idx  (move_idx),
      .fill_id   (donor_tail),
      .fill_done (steal_finish && is_thief),
      .fill_len  (batch_len),
      .head_id   (head_arr[g]),
      .tail_id   (tail_arr[g]),
      .count     (cnt_flat[g*CW +: CW])
    );

    assign gnt_id[g*ID_W +: ID_W] = gid_q[g];
  end

  always_comb begin
    n_srv     = '0;
    n_ack     = '0;
    all_empty = 1'b1;
    for (int i = 0; i < N_SM; i++) begin
      n_srv = n_srv + 16'(serve[i]);
      n_ack = n_ack + 16'(sm_ack[i]);
      if (cnt_flat[i*CW +: CW] != '0) all_empty = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      gnt_valid <= '0;
      out_q     <= '0;
    end else begin
      pending_q <= (pending_q & ~serve) | sm_req;
      gnt_valid <= serve;
      out_q     <= out_q + n_srv - n_ack;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_SM; i++) begin
      if (serve[i]) gid_q[i] <= head_arr[i];
    end
  end

  assign done = all_empty && (out_q == '0) && !steal_busy;

endmodule

// File: rtl/bd_checker.sv
module bd_checker #(
  parameter int N_SM = 4,
  parameter int CW   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SM-1:0]   gnt_valid,
  input logic              load_valid,
  input logic              done,
  input logic              steal_start,
  input logic              steal_busy,
  input logic [N_SM*CW-1:0] cnt_flat,
  input logic [15:0]       peak_q,
  input logic [15:0]       mean_q,
  input logic [15:0]       batch_q
);

  // R8: no grant may leave while a steal begins or moves entries
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (steal_start || steal_busy) |=> (gnt_valid == '0));

  // R3: a grant strobe lasts a single cycle
  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_valid) |=> ((gnt_valid & $past(gnt_valid)) == '0));

  // R9: an idle dispatcher stays idle and silent until new IDs arrive
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load_valid) |=> (done && gnt_valid == '0));

  // R5: a latched steal has a non-zero batch no larger than the peak backlog
  p_batch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    steal_busy |-> (batch_q != '0 && batch_q <= peak_q && mean_q < peak_q));

  for (genvar i = 0; i < N_SM; i++) begin : g_chk
    // R2: a grant only comes from a queue that held an entry
    p_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[i] |-> ($past(cnt_flat[i*CW +: CW]) != '0));
  end

endmodule

bind block_dispatch bd_checker #(.N_SM(N_SM), .CW(CW)) u_bd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gnt_valid   (gnt_valid),
  .load_valid  (load_valid),
  .done        (done),
  .steal_start (steal_start),
  .steal_busy  (steal_busy),
  .cnt_flat    (cnt_flat),
  .peak_q      (peak_q),
  .mean_q      (mean_q),
  .batch_q     (batch_q)
);

// File: tb/block_dispatch_bench.sv
`timescale 1ns/1ps
module block_dispatch_bench;

  localparam int N  = 4;
  localparam int SW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            load_valid = 1'b0;
  logic [SW-1:0]   load_sm = '0;
  logic [15:0]     load_id = '0;
  logic [N-1:0]    sm_req = '0;
  logic [N-1:0]    sm_ack = '0;
  logic [N-1:0]    gnt_valid;
  logic [N*16-1:0] gnt_id;
  logic            done;

  always #2.5 clk = ~clk;

  block_dispatch #(.N_SM(N), .QDEPTH(16)) u_block_dispatch (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_sm(load_sm),
    .load_id(load_id), .sm_req(sm_req), .sm_ack(sm_ack),
    .gnt_valid(gnt_valid), .gnt_id(gnt_id), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] mq     [N][$];
  logic [15:0] exp_q  [N][$];
  string       exp_tag[N][$];
  int          gcount [N];
  int          glast  [N];
  int          seen   [int];
  logic [15:0] loaded [$];
  logic [15:0] mon_id, mon_exp;
  string       mon_tag;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compare each grant against the scoreboard, then acknowledge it
  always @(negedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < N; s++) begin
        if (gnt_valid[s]) begin
          mon_id = gnt_id[s*16 +: 16];
          gcount[s]++;
          glast[s] = cyc;
          if (exp_q[s].size() == 0) begin
            chk(1'b0, "R2 grant with no expected ID", int'(mon_id), 0);
          end else begin
            mon_exp = exp_q[s].pop_front();
            mon_tag = exp_tag[s].pop_front();
            chk(mon_id == mon_exp, mon_tag, int'(mon_id), int'(mon_exp));
          end
          if (seen.exists(int'(mon_id))) seen[int'(mon_id)]++;
          else seen[int'(mon_id)] = 1;
        end
      end
    end
    sm_ack = gnt_valid;
  end

  task automatic load(input int s, input logic [15:0] id);
    @(negedge clk);
    load_valid = 1'b1; load_sm = SW'(s); load_id = id;
    @(negedge clk);
    load_valid = 1'b0;
    mq[s].push_back(id);
    loaded.push_back(id);
  endtask

  // reference steal: donor = first largest backlog, batch = peak - floor(mean)
  task automatic model_steal(input int t, output int k);
    int peak = 0;
    int donor = 0;
    int total = 0;
    for (int s = 0; s < N; s++) begin
      total += mq[s].size();
      if (mq[s].size() > peak) begin peak = mq[s].size(); donor = s; end
    end
    k = peak - total / N;
    for (int j = 0; j < k; j++) mq[t].push_front(mq[donor].pop_back());
  endtask

  task automatic issue(input logic [N-1:0] mask, input bit inject, input string tag);
    int stall = 0;
    int k;
    int c0;
    bit want [N];
    int base [N];
    bit all;
    for (int s = 0; s < N; s++) begin
      if (mask[s] && mq[s].size() == 0) begin
        model_steal(s, k);
        if (k > 0) stall += k + 1;
      end
    end
    for (int s = 0; s < N; s++) begin
      want[s] = 1'b0;
      base[s] = gcount[s];
      if (mask[s] && mq[s].size() != 0) begin
        exp_q[s].push_back(mq[s].pop_front());
        exp_tag[s].push_back(tag);
        want[s] = 1'b1;
      end
    end
    @(negedge clk);
    sm_req = mask; c0 = cyc;
    @(negedge clk);
    sm_req = '0;
    if (inject) begin
      load_valid = 1'b1; load_sm = SW'(1); load_id = 16'hDEAD;
      @(negedge clk);
      load_valid = 1'b0;
    end
    for (int w = 0; w < 40; w++) begin
      all = 1'b1;
      for (int s = 0; s < N; s++) if (want[s] && gcount[s] == base[s]) all = 1'b0;
      if (all) break;
      @(negedge clk);
    end
    for (int s = 0; s < N; s++) begin
      if (want[s]) begin
        chk(gcount[s] == base[s] + 1, {tag, " grant count"}, gcount[s] - base[s], 1);
        if (stall > 0)
          chk(glast[s] - c0 == 2 + stall, "R8 latency across steal", glast[s] - c0, 2 + stall);
        else
          chk(glast[s] - c0 == 2, "R3 grant latency", glast[s] - c0, 2);
      end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin : main
    int g0;
    repeat (4) @(negedge clk);
    chk(gnt_valid == '0, "R1 gnt_valid after reset", int'(gnt_valid), 0);
    chk(done == 1'b1, "R1 done after reset", int'(done), 1);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) load(0, 16'h1000 + 16'(i));
    for (int i = 0; i < 2; i++) load(1, 16'h2000 + 16'(i));
    for (int i = 0; i < 8; i++) load(3, 16'h3000 + 16'(i));
    @(negedge clk);
    chk(done == 1'b0, "R9 done low with queued work", int'(done), 0);

    issue(4'b0010, 1'b0, "R2 single grant");
    g0 = gcount[0];
    issue(4'b1011, 1'b0, "R4 concurrent grant");
    chk(glast[0] == glast[1] && glast[1] == glast[3], "R4 same-edge grants",
        glast[3] - glast[0], 0);

    // counts 7,0,0,7: tie, SM0 donates its last 4; SM0 also served after the stall
    issue(4'b0101, 1'b1, "R5 steal batch tie");
    issue(4'b0010, 1'b0, "R5 steal from busiest");

    for (int s = N - 1; s >= 0; s--)
      while (mq[s].size() > 0) issue(N'(1) << s, 1'b0, "R6 drain order");

    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R9 done after drain and acks", int'(done), 1);

    g0 = gcount[2];
    issue(4'b0100, 1'b0, "R7 empty request");
    repeat (20) @(negedge clk);
    chk(gcount[2] == g0, "R7 no grant on zero batch", gcount[2] - g0, 0);
    chk(done == 1'b1, "R7 done stays high", int'(done), 1);

    load(2, 16'h0777);
    exp_q[2].push_back(mq[2].pop_front());
    exp_tag[2].push_back("R7 pending request served");
    repeat (10) @(negedge clk);
    chk(gcount[2] == g0 + 1, "R7 pending request kept", gcount[2] - g0, 1);
    chk(done == 1'b1, "R9 done after late grant", int'(done), 1);

    chk(!seen.exists(16'hDEAD), "R8 load ignored during steal",
        seen.exists(16'hDEAD) ? 1 : 0, 0);
    foreach (loaded[i]) begin
      chk(seen.exists(int'(loaded[i])) && seen[int'(loaded[i])] == 1,
          "R10 issued exactly once",
          seen.exists(int'(loaded[i])) ? seen[int'(loaded[i])] : 0, 1);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule